// File: doc/BRIEF.md
# Dual Ratio Clock Divider

This block derives two slower clocks from one fast reference clock. The core output divides the reference by a power of two (1, 2, 4 or 8), picked by a two-bit select. The system output divides it by any whole number from 1 to 15, picked by a four-bit select. Both selects sit in one control register. Software may rewrite that register at any time. A new ratio takes effect at the next period boundary of the affected output, with no settling delay, so no output ever shows a shortened high or low phase.

Each output comes in two forms. One is the divided clock itself. The other is a one-cycle strobe in the reference domain that marks the last reference cycle of each divided period. Two more outputs are gated copies of clocks, each with its own enable bit: an off-board copy of the system clock, and a buffered copy of the reference clock. Both enables are set after reset. The register contents can be read back at any time.

Top module: `dual_clk_divider`

## Requirements
- R1: The system output divides the reference by N, the value of control bits [5:2], for N from 1 to 15. `sys_stb` is high for exactly one reference cycle in every N.
- R2: Control bits [1:0] set the core ratio: 00 divides by 1, 01 by 2, 10 by 4 and 11 by 8. `core_stb` is high for one reference cycle in every ratio cycles.
- R3: After reset the control register reads 0xD4. This means core select 00, system select 0101 (divide by 5), and both gate enables set (bit 6 for the off-board copy, bit 7 for the reference copy).
- R4: A new ratio takes effect only at a period boundary. The period running when the write happens finishes at the old ratio, and every later period uses the new one.
- R5: A write whose system select is 0000 leaves the system ratio unchanged. The other fields of that write are still stored.
- R6: In each divided period of N reference cycles, the divided clock is high for the first floor(N/2) cycles and low for the rest.
- R7: At a ratio of 1, the divided clock is the reference clock itself, and the strobe is high in every cycle.
- R8: When bit 6 is set, `ext_clk` copies `sys_clk`. When bit 6 is clear, `ext_clk` stays low. A change of this bit takes effect at the next system period boundary.
- R9: When bit 7 is set, `ref_out` copies `clk_ref`. When bit 7 is clear, `ref_out` stays low. A change of this bit takes effect at the next falling reference edge.
- R10: `cfg_rdata` returns the stored register value from the cycle after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write enable |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Stored register value |
| core_clk | output | 1 | Core divided clock |
| core_stb | output | 1 | Last-cycle strobe of each core period |
| sys_clk | output | 1 | System divided clock |
| sys_stb | output | 1 | Last-cycle strobe of each system period |
| ext_clk | output | 1 | Gated off-board copy of the system clock |
| ref_out | output | 1 | Gated copy of the reference clock |

## Verification
Some properties are checked by assertions on every cycle. These are: each period counter stays below its active ratio, an active ratio changes only on the cycle after a strobe, the stored system select is never zero, and a divided clock is low in the strobe cycle. Other behaviour can only be shown by the bench's scenarios. This covers the exact period lengths and high-phase widths across ratio changes, the one leftover old-ratio period after each write, the rejection of a zero system select, the passthrough at a ratio of 1, and the timing of the two gates.

// File: rtl/cdu_pkg.sv
// Shared widths, control-register layout and reset value for the divider unit.
package cdu_pkg;
    localparam int CORE_SEL_W = 2;
    localparam int SYS_SEL_W  = 4;
    // Core ratio reaches 2**(2**CORE_SEL_W - 1), so this many bits hold it.
    localparam int CORE_RW    = 1 << CORE_SEL_W;
    localparam int SYS_RW     = SYS_SEL_W;

    typedef struct packed {
        logic                  ref_en;    // bit 7
        logic                  ext_en;    // bit 6
        logic [SYS_SEL_W-1:0]  sys_sel;   // bits 5:2
        logic [CORE_SEL_W-1:0] core_sel;  // bits 1:0
    } cdu_ctrl_t;

    localparam int CTRL_W = $bits(cdu_ctrl_t);
    localparam int SYS_RST_RATIO  = 5;
    localparam int CORE_RST_RATIO = 1;
    localparam cdu_ctrl_t CTRL_RST = '{ref_en: 1'b1, ext_en: 1'b1,
                                       sys_sel: SYS_SEL_W'(SYS_RST_RATIO),
                                       core_sel: '0};
endpackage

// File: rtl/cdu_ctrl_reg.sv
// Control register of the divider unit.
// Stores the two ratio selects and the two gate enables.
// A write with a zero system select keeps the previous system select.
// Assumes: writes are synchronous to clk.
module cdu_ctrl_reg
    import cdu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CTRL_W-1:0] wdata,
    output cdu_ctrl_t         ctrl
);
    cdu_ctrl_t wr;
    assign wr = cdu_ctrl_t'(wdata);

    // Store each written field; reject an all-zero system select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= CTRL_RST;
        end else if (we) begin
            ctrl.ref_en   <= wr.ref_en;
            ctrl.ext_en   <= wr.ext_en;
            ctrl.core_sel <= wr.core_sel;
            if (wr.sys_sel != '0)
                ctrl.sys_sel <= wr.sys_sel;
        end
    end

    // R5
    sys_sel_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.sys_sel != '0);
endmodule

// File: rtl/cdu_ratio_div.sv
// Integer clock divider with a ratio loaded at period boundaries.
// It counts reference cycles from 0 to ratio-1. The strobe is high on the
// last count. A requested ratio is taken up only at that boundary.
// The divided clock is high for the first floor(ratio/2) counts.
// A ratio of 1 passes the reference clock straight through.
// Assumes: pend_ratio is never zero.
module cdu_ratio_div #(
    parameter int RW        = 4,
    parameter int RST_RATIO = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] pend_ratio,
    output logic          div_clk,
    output logic          div_stb
);
    logic [RW-1:0] cnt, act, nxt_cnt, nxt_act;
    logic          clk_q;

    assign div_stb = (cnt == act - RW'(1));

    // Next count and ratio: restart and reload at the period boundary.
    always_comb begin
        nxt_act = div_stb ? pend_ratio : act;
        nxt_cnt = div_stb ? '0 : cnt + RW'(1);
    end

    // Advance the counter and shape the divided clock from the next count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            act   <= RW'(RST_RATIO);
            clk_q <= (RST_RATIO > 1);
        end else begin
            cnt   <= nxt_cnt;
            act   <= nxt_act;
            clk_q <= (nxt_cnt < (nxt_act >> 1));
        end
    end

    assign div_clk = (act == RW'(1)) ? clk : clk_q;

    // R1
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < act);
    // R4
    ratio_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act != $past(act)) |-> $past(div_stb));
    // R5
    pend_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_ratio != '0);
    // R6
    stb_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_stb && act > RW'(1)) |-> !clk_q);
endmodule

// File: rtl/cdu_clk_gate.sv
// Clock gate whose enable is captured on the falling reference edge.
// The enable is captured only when load is high. Callers pick a moment
// when the gated clock is low, so that no partial pulse can appear.
// Assumes: clk_in is low while clk is low whenever load is high.
module cdu_clk_gate #(
    parameter bit RST_EN = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_in,
    input  logic en,
    input  logic load,
    output logic gclk
);
    logic en_q;

    // Take up the new enable on a falling edge at a caller-chosen moment.
    always_ff @(negedge clk) begin
        if (!rst_n)
            en_q <= RST_EN;
        else if (load)
            en_q <= en;
    end

    assign gclk = clk_in & en_q;
endmodule

// File: rtl/dual_clk_divider.sv
// Dual ratio clock divider, top level.
// A control register feeds a power-of-two core divider and an integer
// system divider. Two clock gates produce the off-board system copy and
// the buffered reference copy.
// Assumes: clk_ref is the only clock and rst_n is synchronous to it.
module dual_clk_divider
    import cdu_pkg::*;
(
    input  logic              clk_ref,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CTRL_W-1:0] cfg_wdata,
    output logic [CTRL_W-1:0] cfg_rdata,
    output logic              core_clk,
    output logic              core_stb,
    output logic              sys_clk,
    output logic              sys_stb,
    output logic              ext_clk,
    output logic              ref_out
);
    cdu_ctrl_t          ctrl;
    logic [CORE_RW-1:0] core_pend;
    logic [SYS_RW-1:0]  sys_pend;

    cdu_ctrl_reg u_reg (
        .clk(clk_ref), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .ctrl(ctrl)
    );

    assign cfg_rdata = ctrl;
    // Core select is an exponent; the system select is the ratio itself.
    assign core_pend = CORE_RW'(1) << ctrl.core_sel;
    assign sys_pend  = ctrl.sys_sel;

    cdu_ratio_div #(.RW(CORE_RW), .RST_RATIO(CORE_RST_RATIO)) u_core_div (
        .clk(clk_ref), .rst_n(rst_n), .pend_ratio(core_pend),
        .div_clk(core_clk), .div_stb(core_stb)
    );

    cdu_ratio_div #(.RW(SYS_RW), .RST_RATIO(SYS_RST_RATIO)) u_sys_div (
        .clk(clk_ref), .rst_n(rst_n), .pend_ratio(sys_pend),
        .div_clk(sys_clk), .div_stb(sys_stb)
    );

    // Off-board copy: the enable changes only in the last cycle of a system period.
    cdu_clk_gate #(.RST_EN(1'b1)) u_ext_gate (
        .clk(clk_ref), .rst_n(rst_n), .clk_in(sys_clk), .en(ctrl.ext_en),
        .load(sys_stb), .gclk(ext_clk)
    );

    // Reference copy: the enable changes on any falling edge.
    cdu_clk_gate #(.RST_EN(1'b1)) u_ref_gate (
        .clk(clk_ref), .rst_n(rst_n), .clk_in(clk_ref), .en(ctrl.ref_en),
        .load(1'b1), .gclk(ref_out)
    );
endmodule

// File: tb/dual_clk_divider_test.sv
// Scoreboard bench. Driver tasks push the expected period lengths and
// high-phase widths. Monitors sample on falling edges and compare.
module dual_clk_divider_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       we = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic core_clk, core_stb, sys_clk, sys_stb, ext_clk, ref_out;

    dual_clk_divider uut (
        .clk_ref(clk), .rst_n(rst_n), .cfg_we(we), .cfg_wdata(wdata),
        .cfg_rdata(rdata), .core_clk(core_clk), .core_stb(core_stb),
        .sys_clk(sys_clk), .sys_stb(sys_stb), .ext_clk(ext_clk), .ref_out(ref_out)
    );

    always #5 clk = ~clk;

    typedef struct { int period; int highs; string tag; } exp_t;
    exp_t sys_q[$];
    exp_t core_q[$];
    int n_tests = 0, n_fail = 0;
    int sys_len = 0, sys_hi = 0, core_len = 0, core_hi = 0;
    logic [7:0] cur = 8'hD4;
    int exp_sys = 5, exp_core = 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Monitor: measure each system period and its high phase, then compare.
    always @(negedge clk) begin : sys_mon
        exp_t e;
        if (rst_n) begin
            sys_len++;
            if (sys_clk) sys_hi++;
            if (sys_stb) begin
                if (sys_q.size() > 0) begin
                    e = sys_q.pop_front();
                    chk(sys_len == e.period, {e.tag, " sys period"}, sys_len, e.period);
                    chk(sys_hi == e.highs, "R6 sys high phase", sys_hi, e.highs);
                end
                sys_len = 0;
                sys_hi  = 0;
            end
        end
    end

    // Monitor: measure each core period and its high phase, then compare.
    always @(negedge clk) begin : core_mon
        exp_t e;
        if (rst_n) begin
            core_len++;
            if (core_clk) core_hi++;
            if (core_stb) begin
                if (core_q.size() > 0) begin
                    e = core_q.pop_front();
                    chk(core_len == e.period, {e.tag, " core period"}, core_len, e.period);
                    chk(core_hi == e.highs, "R6 core high phase", core_hi, e.highs);
                end
                core_len = 0;
                core_hi  = 0;
            end
        end
    end

    task automatic push_sys(input int n, input string tag);
        exp_t e;
        e.period = n; e.highs = n / 2; e.tag = tag;
        sys_q.push_back(e);
    endtask

    task automatic push_core(input int n, input string tag);
        exp_t e;
        e.period = n; e.highs = n / 2; e.tag = tag;
        core_q.push_back(e);
    endtask

    // Plain register write; returns after the write has been captured.
    task automatic wr_reg(input logic [7:0] v);
        @(negedge clk);
        we = 1'b1; wdata = v;
        @(negedge clk);
        we = 1'b0;
        cur = (v[5:2] == 4'd0) ? {v[7:6], cur[5:2], v[1:0]} : v;
    endtask

    // Driver: write a new system select just after a strobe and queue the expected periods.
    task automatic sys_change(input int sel);
        int nn;
        do @(negedge clk); while (!sys_stb);
        #1;
        nn = (sel == 0) ? exp_sys : sel;
        push_sys(exp_sys, "R4 old ratio");
        for (int i = 0; i < 3; i++) push_sys(nn, (sel == 0) ? "R5" : "R1");
        we = 1'b1; wdata = {cur[7:6], 4'(sel), cur[1:0]};
        @(negedge clk);
        we = 1'b0;
        if (sel != 0) cur[5:2] = 4'(sel);
        exp_sys = nn;
        while (sys_q.size() > 0) @(negedge clk);
    endtask

    // Driver: write a new core select just after a core strobe.
    task automatic core_change(input int sel);
        int nn;
        do @(negedge clk); while (!core_stb);
        #1;
        nn = 1 << sel;
        push_core(exp_core, "R4 old ratio");
        for (int i = 0; i < 3; i++) push_core(nn, "R2");
        we = 1'b1; wdata = {cur[7:2], 2'(sel)};
        @(negedge clk);
        we = 1'b0;
        cur[1:0] = 2'(sel);
        exp_core = nn;
        while (core_q.size() > 0) @(negedge clk);
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int bad;
        repeat (3) @(posedge clk);
        for (int i = 0; i < 3; i++) push_sys(5, "R3 reset ratio");
        for (int i = 0; i < 3; i++) push_core(1, "R3 reset ratio");
        @(posedge clk); #1 rst_n = 1'b1;
        #2 chk(rdata == 8'hD4, "R3 reset register", rdata, 8'hD4);
        while (sys_q.size() > 0 || core_q.size() > 0) @(negedge clk);

        sys_change(6);
        sys_change(10);
        sys_change(15);
        sys_change(7);
        sys_change(0);
        @(negedge clk);
        chk(rdata[5:2] == 4'd7, "R5 zero select kept", rdata[5:2], 7);
        sys_change(1);
        // R7: passthrough follows the reference clock
        @(posedge clk); #1;
        chk(sys_clk == 1'b1, "R7 passthrough high", sys_clk, 1);
        chk(sys_stb == 1'b1, "R7 strobe every cycle", sys_stb, 1);
        chk(ext_clk == 1'b1, "R8 copy enabled", ext_clk, 1);
        @(negedge clk); #1;
        chk(sys_clk == 1'b0, "R7 passthrough low", sys_clk, 0);
        sys_change(4);

        core_change(1);
        core_change(2);
        core_change(3);
        core_change(0);

        // R8: off-board copy held low once disabled
        wr_reg({cur[7], 1'b0, cur[5:0]});
        repeat (3) begin do @(negedge clk); while (!sys_stb); end
        bad = 0;
        for (int i = 0; i < 12; i++) begin
            @(posedge clk); #1 if (ext_clk) bad++;
            @(negedge clk); #1 if (ext_clk) bad++;
        end
        chk(bad == 0, "R8 copy disabled", bad, 0);
        wr_reg({cur[7], 1'b1, cur[5:0]});
        repeat (3) begin do @(negedge clk); while (!sys_stb); end
        bad = 0;
        for (int i = 0; i < 12; i++) begin
            @(posedge clk); #1 if (ext_clk != sys_clk) bad++;
            @(negedge clk); #1 if (ext_clk != sys_clk) bad++;
        end
        chk(bad == 0, "R8 copy re-enabled", bad, 0);

        // R9: reference copy gating
        @(posedge clk); #1;
        chk(ref_out == 1'b1, "R9 reference copy on", ref_out, 1);
        wr_reg({1'b0, cur[6:0]});
        repeat (2) @(negedge clk);
        @(posedge clk); #1;
        chk(ref_out == 1'b0, "R9 reference copy off", ref_out, 0);
        wr_reg({1'b1, cur[6:0]});
        repeat (2) @(negedge clk);
        @(posedge clk); #1;
        chk(ref_out == 1'b1, "R9 reference copy restored", ref_out, 1);

        // R10: read-back after a full write
        wr_reg(8'b0110_1110);
        #1 chk(rdata == 8'h6E, "R10 read-back", rdata, 8'h6E);

        finish_run();
    end
endmodule